// File: doc/BRIEF.md
# Spectral Subtraction Magnitude Unit

This block performs the magnitude step of spectral noise subtraction. For every frequency bin it receives the magnitude of the noisy signal and an estimate of the noise magnitude in that bin. It scales the noise estimate by an over-subtraction factor and removes it from the signal magnitude. It also scales the signal magnitude by a spectral floor factor. A comparator then chooses the larger of the two, so the cleaned magnitude never drops below a fixed fraction of the original.

Both factors sit in registers that can be written at any time. They take preset values on reset. The block takes one bin per cycle when its input strobe is high, and it returns the result one cycle later with a matching strobe. Producing the magnitudes, restoring phase and the inverse transform are handled by other blocks.

Top module: `spec_sub_unit`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `out_mag` is 0. The over-subtraction factor resets to 0x20 (2.0) and the floor factor resets to 0x1A (26/256).
- R2: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high. It is low in the cycle after an edge at which `in_valid` was low.
- R3: The over-subtraction factor is unsigned Q4.4. The scaled noise is floor(`noise_mag`·alpha/16), kept at 20 bits. The difference is `sig_mag` minus the scaled noise.
- R4: The floor factor is unsigned Q0.8. The floor value is floor(`sig_mag`·beta/256), which is 16 bits wide.
- R5: When the difference is strictly greater than the floor value, `out_mag` is the difference. When the two are equal or the difference is smaller, `out_mag` is the floor value.
- R6: When the difference is negative, `out_mag` is the floor value.
- R7: A factor write (`alpha_we` or `beta_we`) changes the factor at that clock edge. A sample taken at the same edge still uses the old factor. Samples taken from the next edge on use the new one.
- R8: While `in_valid` is low, `out_mag` keeps its last value.
- R9: With alpha = 0, `out_mag` equals `sig_mag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A bin is presented on the magnitude inputs |
| sig_mag | input | 16 | Signal magnitude, unsigned |
| noise_mag | input | 16 | Noise magnitude estimate, unsigned |
| alpha_we | input | 1 | Write strobe for the over-subtraction factor |
| alpha_wdata | input | 8 | New over-subtraction factor, Q4.4 |
| beta_we | input | 1 | Write strobe for the floor factor |
| beta_wdata | input | 8 | New floor factor, Q0.8 |
| out_valid | output | 1 | Result strobe |
| out_mag | output | 16 | Noise-reduced magnitude |

## Verification
Each result is due one edge after its sample: the sample is taken at edge t and the result is visible from edge t+1 onwards. A factor write takes effect at its own edge, so it affects the results of samples taken after that edge. The bench's reference model works out the expected strobe and magnitude at each rising edge from the inputs and the factors held before that edge, and then applies any writes. The outputs are compared at the following falling edge, after the design's register has settled.

// File: rtl/ss_pkg.sv
package ss_pkg;
  localparam int unsigned MAG_W       = 16;
  localparam int unsigned FACT_W      = 8;
  localparam int unsigned ALPHA_FRAC  = 4;
  localparam int unsigned BETA_FRAC   = 8;
  localparam logic [FACT_W-1:0] ALPHA_DEFAULT = 8'h20;
  localparam logic [FACT_W-1:0] BETA_DEFAULT  = 8'h1A;
endpackage

// File: rtl/ss_factor_reg.sv
module ss_factor_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= RST_VAL;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/ss_scaler.sv
module ss_scaler #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned F_W   = 8,
  parameter int unsigned FRAC  = 4,
  localparam int unsigned PROD_W = IN_W + F_W,
  localparam int unsigned OUT_W  = PROD_W - FRAC
) (
  input  logic [IN_W-1:0]  mag,
  input  logic [F_W-1:0]   factor,
  output logic [OUT_W-1:0] scaled
);
  logic [PROD_W-1:0] prod;
  logic              unused_frac;

  always_comb prod = PROD_W'(mag) * PROD_W'(factor);

  generate
    if (FRAC > 0) begin : g_drop
      assign scaled      = prod[PROD_W-1:FRAC];
      assign unused_frac = ^prod[FRAC-1:0];
    end else begin : g_keep
      assign scaled      = prod;
      assign unused_frac = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ss_select.sv
module ss_select #(
  parameter int unsigned MAG_W   = 16,
  parameter int unsigned NOISE_W = 20,
  localparam int unsigned SW = ((NOISE_W > MAG_W) ? NOISE_W : MAG_W) + 1
) (
  input  logic [MAG_W-1:0]   sig,
  input  logic [NOISE_W-1:0] noise_scaled,
  input  logic [MAG_W-1:0]   floor_val,
  output logic [MAG_W-1:0]   result
);
  logic signed [SW-1:0] diff;
  logic                 neg;
  logic                 above;
  logic                 unused_hi;

  always_comb begin
    diff  = $signed(SW'(sig)) - $signed(SW'(noise_scaled));
    neg   = diff[SW-1];
    above = !neg && (diff > $signed(SW'(floor_val)));
    result = above ? diff[MAG_W-1:0] : floor_val;
  end

  assign unused_hi = ^diff[SW-1:MAG_W];
endmodule

// File: rtl/spec_sub_unit.sv
module spec_sub_unit
  import ss_pkg::*;
#(
  parameter int unsigned DATA_W = MAG_W,
  parameter int unsigned FW     = FACT_W,
  parameter int unsigned AFRAC  = ALPHA_FRAC,
  parameter int unsigned BFRAC  = BETA_FRAC,
  parameter logic [FW-1:0] ALPHA_RST = ALPHA_DEFAULT,
  parameter logic [FW-1:0] BETA_RST  = BETA_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] sig_mag,
  input  logic [DATA_W-1:0] noise_mag,
  input  logic              alpha_we,
  input  logic [FW-1:0]     alpha_wdata,
  input  logic              beta_we,
  input  logic [FW-1:0]     beta_wdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_mag
);
  localparam int unsigned NS_W = DATA_W + FW - AFRAC;
  localparam int unsigned FL_W = DATA_W + FW - BFRAC;

  logic [FW-1:0]     alpha_q;
  logic [FW-1:0]     beta_q;
  logic [NS_W-1:0]   noise_scaled;
  logic [FL_W-1:0]   floor_full;
  logic [DATA_W-1:0] floor_val;
  logic [DATA_W-1:0] pick;

  ss_factor_reg #(.W(FW), .RST_VAL(ALPHA_RST)) u_alpha (
    .clk(clk), .rst(rst), .we(alpha_we), .wdata(alpha_wdata), .q(alpha_q));
  ss_factor_reg #(.W(FW), .RST_VAL(BETA_RST)) u_beta (
    .clk(clk), .rst(rst), .we(beta_we), .wdata(beta_wdata), .q(beta_q));

  ss_scaler #(.IN_W(DATA_W), .F_W(FW), .FRAC(AFRAC)) u_noise_scale (
    .mag(noise_mag), .factor(alpha_q), .scaled(noise_scaled));
  ss_scaler #(.IN_W(DATA_W), .F_W(FW), .FRAC(BFRAC)) u_floor_scale (
    .mag(sig_mag), .factor(beta_q), .scaled(floor_full));

  generate
    if (FL_W > DATA_W) begin : g_floor_trunc
      assign floor_val = floor_full[DATA_W-1:0];
    end else begin : g_floor_ext
      assign floor_val = DATA_W'(floor_full);
    end
  endgenerate

  ss_select #(.MAG_W(DATA_W), .NOISE_W(NS_W)) u_select (
    .sig(sig_mag), .noise_scaled(noise_scaled), .floor_val(floor_val),
    .result(pick));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mag   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_mag <= pick;
    end
  end
endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned FW     = 8,
  parameter int unsigned BFRAC  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] sig_mag,
  input logic              alpha_we,
  input logic [FW-1:0]     alpha_wdata,
  input logic              beta_we,
  input logic [FW-1:0]     beta_wdata,
  input logic [FW-1:0]     alpha_q,
  input logic [FW-1:0]     beta_q,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_mag
);
  localparam int unsigned PW = DATA_W + FW;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_mag)); // R8
  AST_NOT_BELOW_FLOOR: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (PW'(out_mag) >=
      ((PW'($past(sig_mag)) * PW'($past(beta_q))) >> BFRAC))); // R5
  AST_NOT_ABOVE_SIG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_mag <= $past(sig_mag)); // R6
  AST_ALPHA_WRITE: assert property (@(posedge clk) disable iff (rst)
    alpha_we |=> alpha_q == $past(alpha_wdata)); // R7
  AST_BETA_WRITE: assert property (@(posedge clk) disable iff (rst)
    beta_we |=> beta_q == $past(beta_wdata)); // R7
endmodule

bind spec_sub_unit ss_checker #(.DATA_W(DATA_W), .FW(FW), .BFRAC(BFRAC)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sig_mag(sig_mag),
  .alpha_we(alpha_we), .alpha_wdata(alpha_wdata),
  .beta_we(beta_we), .beta_wdata(beta_wdata),
  .alpha_q(alpha_q), .beta_q(beta_q),
  .out_valid(out_valid), .out_mag(out_mag));

// File: tb/sim_spec_sub_unit.sv
`timescale 1ns/1ps
module sim_spec_sub_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] sig_mag = '0;
  logic [15:0] noise_mag = '0;
  logic        alpha_we = 1'b0;
  logic [7:0]  alpha_wdata = '0;
  logic        beta_we = 1'b0;
  logic [7:0]  beta_wdata = '0;
  logic        out_valid;
  logic [15:0] out_mag;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  int    m_alpha, m_beta, exp_mag;
  bit    exp_valid;
  string exp_tag;
  bit    r7_next;

  always #5 clk = ~clk;

  spec_sub_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sig_mag(sig_mag),
    .noise_mag(noise_mag), .alpha_we(alpha_we), .alpha_wdata(alpha_wdata),
    .beta_we(beta_we), .beta_wdata(beta_wdata),
    .out_valid(out_valid), .out_mag(out_mag));

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  // reference model: evaluated at each rising edge with pre-edge values
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      exp_valid = 0; exp_mag = 0; m_alpha = 'h20; m_beta = 'h1A;
      exp_tag = "R1"; r7_next = 0;
    end else begin
      exp_valid = in_valid;
      if (in_valid) begin
        int a, d, fl;
        a  = int'(sig_mag);
        d  = a - (int'(noise_mag) * m_alpha) / 16;   // R3
        fl = (a * m_beta) / 256;                      // R4
        exp_mag = (d > fl) ? d : fl;
        if (r7_next || alpha_we || beta_we) exp_tag = "R7";
        else if (m_alpha == 0) exp_tag = "R9";
        else if (d < 0) exp_tag = "R6";
        else exp_tag = "R5";
        r7_next = alpha_we || beta_we;
      end else begin
        exp_tag = "R8";
        if (alpha_we || beta_we) r7_next = 1;
      end
      if (alpha_we) m_alpha = int'(alpha_wdata);
      if (beta_we)  m_beta  = int'(beta_wdata);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2", int'(out_valid), int'(exp_valid));
      check(exp_tag, int'(out_mag), exp_mag);
    end
  end

  task automatic put(input bit v, input int a, input int b);
    @(negedge clk);
    in_valid = v; sig_mag = 16'(a); noise_mag = 16'(b);
    alpha_we = 0; beta_we = 0;
  endtask

  task automatic put_cfg(input bit v, input int a, input int b,
                         input bit aw, input int av, input bit bw, input int bv);
    @(negedge clk);
    in_valid = v; sig_mag = 16'(a); noise_mag = 16'(b);
    alpha_we = aw; alpha_wdata = 8'(av); beta_we = bw; beta_wdata = 8'(bv);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [31:0] lf;
    lf = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_mag), 0);
    @(negedge clk); rst = 1'b0;
    put(1, 1000, 100);            // R3 R5 defaults: 800
    put(1, 1000, 600);            // R6: floor 101
    put(0, 5, 5);                 // R8 hold
    put(0, 9, 9);
    put_cfg(1, 200, 100, 1, 16, 1, 128);  // R7 old factors used
    put(1, 200, 100);             // R5 equal case with new factors
    put(1, 300, 100);             // R5 200 > 150
    put_cfg(1, 4000, 9000, 1, 0, 0, 0);
    put(1, 4000, 9000);           // R9 alpha 0
    put(1, 0, 0);
    put_cfg(1, 65535, 65535, 1, 255, 1, 255);
    put(1, 65535, 65535);         // R6 extreme
    put(1, 65535, 0);
    for (int i = 0; i < 400; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      put_cfg(lf[0] | lf[1], int'(lf[31:16]), int'(lf[15:0]) >> lf[3:2],
              lf[4] & lf[5] & lf[6], int'(lf[15:8]),
              lf[7] & lf[8] & lf[9], int'(lf[23:16]));
    end
    put(0, 0, 0);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule